// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the slave side of a four-wire serial link that gives access to a byte-wide memory. It runs on a fast system clock and oversamples the link pins. The serial clock, select, data-in and pause inputs each cross into the system clock domain through two flip-flops. Edges of the serial clock are then found by comparing consecutive samples. The master may use either clock polarity pair in which data is captured on the rising edge: the clock idles low (mode 0) or idles high (mode 3). The system clock must run at least four times faster than the serial clock.

Every transaction opens with a falling select and an eight-bit command, most significant bit first. The commands that move array data are followed by a sixteen-bit address. Two kinds of unit sit behind the block. The write-enable and protection logic receives single-cycle strobes for the enable, disable and status-write commands. The page-write logic receives one strobe per received data byte, with its address. Array reads use a synchronous memory port that returns data on the cycle after a request and then holds it. Status reads return a byte supplied by the protection logic. The serial output has a separate drive-enable output so that the pad can be tri-stated.

Top module: `serial_mem_front`

## Requirements
- R1: Command bytes are taken most significant bit first, and the upper nibble must be zero. Bit 3 is ignored. The low three bits select the command: 110 set write enable, 100 clear write enable, 101 status read, 001 status write, 011 array read, 010 array write. Set and clear each raise a one-cycle strobe.
- R2: A command byte with a nonzero upper nibble, or with low bits 000 or 111, locks the interface. No strobe follows, no read is requested, and the output stays undriven until select is released and asserted again.
- R3: While select is high, serial clock edges and data-in are ignored and the output is undriven. The next low select starts a fresh command.
- R4: While pause is low, serial clock edges are ignored, the output is undriven, and the bit position is kept. After pause is released the transfer resumes at the same bit.
- R5: An array read takes a sixteen-bit address, of which only the low AW bits are used. A memory read request is issued when the last address bit is sampled. The data byte then leaves on the output, most significant bit first.
- R6: An array read continues for as long as select stays low. The address increases by one for each byte and wraps from the top of the array to zero. Each new request is a single-cycle pulse.
- R7: A status read returns the status input byte repeatedly. The status input is sampled again at the start of each byte.
- R8: A status write takes exactly one data byte and presents it with a one-cycle strobe. Any further bits in the same transaction are ignored.
- R9: An array write presents each received data byte with a one-cycle strobe and its address. After each byte only the low PW address bits advance, wrapping within the page.
- R10: While the busy input is high, every command except status read is dropped with no strobe and no output drive.
- R11: The output changes only after a falling serial clock edge, so it is stable while the serial clock is high.
- R12: Mode 3 (clock idling high) yields the same results as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for so |
| busy | input | 1 | Internal write cycle in progress |
| status_in | input | 8 | Status byte returned by a status read |
| wen_set | output | 1 | Set-write-enable strobe |
| wen_clr | output | 1 | Clear-write-enable strobe |
| sr_wr_valid | output | 1 | Status-write byte strobe |
| wr_valid | output | 1 | Array-write byte strobe |
| wr_addr | output | AW | Address of the array-write byte |
| rx_byte | output | 8 | Received data byte for either write |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | 8 | Memory read data, valid the cycle after the request |

## Verification
The assertions check on every cycle the properties that need no knowledge of the command stream. These are: the output is quiet after select goes high, the output is quiet in the locked state, the output changes only after a detected falling clock, the sequence is frozen while pause is low, strobes never overlap, read requests are single pulses, and busy drops any command other than a status read. Only the directed scenarios can show the results that depend on content. These include the data values coming back, address wrap across the array and within a page, status bytes being sampled again mid-stream, lockout and recovery after a bad command, and matching results in both clock modes.

// File: rtl/smf_pkg.sv
package smf_pkg;

    localparam int OPW = 8;
    localparam int ADW = 16;

    typedef enum logic [2:0] {
        PH_OP,
        PH_ADDR,
        PH_RX,
        PH_TX,
        PH_LOCK
    } phase_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_WEN_SET,
        OP_WEN_CLR,
        OP_STAT_RD,
        OP_STAT_WR,
        OP_ARR_RD,
        OP_ARR_WR
    } opk_t;

    typedef struct packed {
        logic wen_set;
        logic wen_clr;
        logic sr_wr;
        logic arr_wr;
        logic rd_req;
    } strobe_t;

    // Upper nibble must be clear; bit 3 is ignored.
    function automatic opk_t decode_op(input logic [OPW-1:0] b);
        opk_t k;
        k = OP_NONE;
        if (b[7:4] == 4'h0) begin
            case (b[2:0])
                3'b110:  k = OP_WEN_SET;
                3'b100:  k = OP_WEN_CLR;
                3'b101:  k = OP_STAT_RD;
                3'b001:  k = OP_STAT_WR;
                3'b011:  k = OP_ARR_RD;
                3'b010:  k = OP_ARR_WR;
                default: k = OP_NONE;
            endcase
        end
        return k;
    endfunction

    // Advance only the low pw bits, keeping the page.
    function automatic logic [ADW-1:0] page_step(input logic [ADW-1:0] a, input int pw);
        logic [ADW-1:0] mask;
        mask = (ADW'(1) << pw) - ADW'(1);
        return (a & ~mask) | ((a + ADW'(1)) & mask);
    endfunction

endpackage

// File: rtl/smf_sync.sv
module smf_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta <= RST_VAL[g];
                q[g] <= RST_VAL[g];
            end else begin
                meta <= d[g];
                q[g] <= meta;
            end
        end
    end
endmodule

// File: rtl/smf_tx.sv
module smf_tx #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          shift,
    input  logic [BW-1:0] byte_in,
    output logic          so
);
    logic [BW-1:0] rest;

    always_ff @(posedge clk) begin
        if (rst) begin
            rest <= '0;
            so   <= 1'b0;
        end else if (load) begin
            so   <= byte_in[BW-1];
            rest <= {byte_in[BW-2:0], 1'b0};
        end else if (shift) begin
            so   <= rest[BW-1];
            rest <= {rest[BW-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/serial_mem_front.sv
module serial_mem_front
    import smf_pkg::*;
#(
    parameter int AW = 12,
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sck,
    input  logic          cs_n,
    input  logic          si,
    input  logic          hold_n,
    output logic          so,
    output logic          so_oe,
    input  logic          busy,
    input  logic [7:0]    status_in,
    output logic          wen_set,
    output logic          wen_clr,
    output logic          sr_wr_valid,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    rx_byte,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_rd_addr,
    input  logic [7:0]    mem_rd_data
);
    localparam int CNTW = $clog2(ADW);
    localparam logic [CNTW-1:0] LAST_BYTE_BIT = CNTW'(OPW - 1);
    localparam logic [CNTW-1:0] LAST_ADDR_BIT = CNTW'(ADW - 1);

    // ---- pin synchronisers ----
    logic [3:0] pins_s;
    logic cs_n_s, hold_n_s, sck_s, si_s;

    smf_sync #(.W(4), .RST_VAL(4'b1100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, hold_n, sck, si}),
        .q   (pins_s)
    );
    assign {cs_n_s, hold_n_s, sck_s, si_s} = pins_s;

    logic sck_q;
    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck_s;
    end

    logic sck_rise, sck_fall, run;
    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;
    assign run      = ~cs_n_s & hold_n_s;

    // ---- sequencer ----
    phase_t          phase;
    opk_t            opk;
    logic [CNTW-1:0] cnt;
    logic [ADW-1:0]  shreg;
    logic [ADW-1:0]  nxt;
    logic [AW-1:0]   addr_q;
    strobe_t         stb;
    logic            out_active;
    opk_t            op_dec;

    always_comb begin
        nxt    = {shreg[ADW-2:0], si_s};
        op_dec = decode_op(nxt[OPW-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_OP;
            opk         <= OP_NONE;
            cnt         <= '0;
            shreg       <= '0;
            addr_q      <= '0;
            stb         <= '0;
            out_active  <= 1'b0;
            wr_addr     <= '0;
            rx_byte     <= '0;
            mem_rd_addr <= '0;
        end else begin
            stb <= '0;
            if (cs_n_s) begin
                phase      <= PH_OP;
                cnt        <= '0;
                out_active <= 1'b0;
            end else if (run && sck_rise) begin
                shreg <= nxt;
                cnt   <= cnt + 1'b1;
                case (phase)
                    PH_OP: if (cnt == LAST_BYTE_BIT) begin
                        cnt <= '0;
                        opk <= op_dec;
                        if (op_dec == OP_NONE || (busy && op_dec != OP_STAT_RD)) begin
                            phase <= PH_LOCK;
                        end else begin
                            case (op_dec)
                                OP_WEN_SET: begin stb.wen_set <= 1'b1; phase <= PH_LOCK; end
                                OP_WEN_CLR: begin stb.wen_clr <= 1'b1; phase <= PH_LOCK; end
                                OP_STAT_RD: phase <= PH_TX;
                                OP_STAT_WR: phase <= PH_RX;
                                default:    phase <= PH_ADDR;
                            endcase
                        end
                    end
                    PH_ADDR: if (cnt == LAST_ADDR_BIT) begin
                        cnt    <= '0;
                        addr_q <= nxt[AW-1:0];
                        if (opk == OP_ARR_RD) begin
                            stb.rd_req  <= 1'b1;
                            mem_rd_addr <= nxt[AW-1:0];
                            phase       <= PH_TX;
                        end else begin
                            phase <= PH_RX;
                        end
                    end
                    PH_RX: if (cnt == LAST_BYTE_BIT) begin
                        cnt     <= '0;
                        rx_byte <= nxt[OPW-1:0];
                        if (opk == OP_STAT_WR) begin
                            stb.sr_wr <= 1'b1;
                            phase     <= PH_LOCK;
                        end else begin
                            stb.arr_wr <= 1'b1;
                            wr_addr    <= addr_q;
                            addr_q     <= AW'(page_step(ADW'(addr_q), PW));
                        end
                    end
                    PH_TX: if (cnt == LAST_BYTE_BIT) begin
                        cnt <= '0;
                        if (opk == OP_ARR_RD) begin
                            addr_q      <= addr_q + 1'b1;
                            mem_rd_addr <= addr_q + 1'b1;
                            stb.rd_req  <= 1'b1;
                        end
                    end
                    default: cnt <= cnt;
                endcase
            end
            if (run && sck_fall && phase == PH_TX && cnt == '0) out_active <= 1'b1;
        end
    end

    // ---- output shifter ----
    logic tx_load, tx_shift;
    assign tx_load  = run && sck_fall && phase == PH_TX && cnt == '0;
    assign tx_shift = run && sck_fall && phase == PH_TX && cnt != '0;

    smf_tx #(.BW(OPW)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .load    (tx_load),
        .shift   (tx_shift),
        .byte_in ((opk == OP_STAT_RD) ? status_in : mem_rd_data),
        .so      (so)
    );

    assign so_oe       = out_active & hold_n_s & ~cs_n_s;
    assign wen_set     = stb.wen_set;
    assign wen_clr     = stb.wen_clr;
    assign sr_wr_valid = stb.sr_wr;
    assign wr_valid    = stb.arr_wr;
    assign mem_rd_en   = stb.rd_req;

    // ---- assertions ----
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end

    p_deselect_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(cs_n, 2)) |-> !so_oe);

    p_lock_silent_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOCK) |-> !so_oe);

    p_strobe_excl_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb));

    p_rdreq_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

    p_so_after_fall_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(sck_fall) |-> $stable(so));

    p_hold_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(hold_n_s) && !$past(cs_n_s)) |-> ($stable(cnt) && $stable(phase)));

    p_busy_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && run && sck_rise && phase == PH_OP && cnt == LAST_BYTE_BIT
         && op_dec != OP_STAT_RD) |=> (phase == PH_LOCK && stb == '0));

endmodule

// File: tb/serial_mem_front_tb.sv
module serial_mem_front_tb_top;

    localparam int AW   = 12;
    localparam int PW   = 5;
    localparam time HALF = 20ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
    logic [7:0] status_in = 8'h00;
    logic so, so_oe, wen_set, wen_clr, sr_wr_valid, wr_valid, mem_rd_en;
    logic [AW-1:0] wr_addr, mem_rd_addr;
    logic [7:0] rx_byte;
    logic [7:0] mem_rd_data = 8'h00;

    always #2.5ns clk = ~clk;

    serial_mem_front #(.AW(AW), .PW(PW)) dut_i (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .busy(busy), .status_in(status_in),
        .wen_set(wen_set), .wen_clr(wen_clr), .sr_wr_valid(sr_wr_valid),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .rx_byte(rx_byte),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
    );

    function automatic logic [7:0] fmem(input logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], 4'h9};
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= fmem(mem_rd_addr);

    // ---- monitors (sole writers of their counters) ----
    int wen_n = 0, clr_n = 0, sr_n = 0, wr_n = 0, rd_n = 0, oe_n = 0, viol_n = 0;
    logic [7:0]    sr_last = 8'h00;
    logic [AW-1:0] wr_a_log [64];
    logic [7:0]    wr_d_log [64];
    logic [AW-1:0] rd_a_log [64];
    logic prev_sck = 1'b0, prev_so = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (wen_set) wen_n++;
            if (wen_clr) clr_n++;
            if (sr_wr_valid) begin sr_n++; sr_last = rx_byte; end
            if (wr_valid) begin wr_a_log[wr_n % 64] = wr_addr; wr_d_log[wr_n % 64] = rx_byte; wr_n++; end
            if (mem_rd_en) begin rd_a_log[rd_n % 64] = mem_rd_addr; rd_n++; end
            if (so_oe === 1'b1) oe_n++;
            if (sck && prev_sck && so_oe && so !== prev_so) viol_n++;
        end
        prev_sck = sck;
        prev_so  = so;
    end

    // ---- check helpers ----
    int n_chk = 0, n_fail = 0;
    bit mode3 = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sel();
        sck = mode3;
        #HALF;
        cs_n = 1'b0;
        #HALF;
    endtask

    task automatic desel();
        if (!mode3) begin sck = 1'b0; #HALF; end
        cs_n = 1'b1;
        #(2*HALF);
    endtask

    task automatic pause_here();
        int b;
        sck = 1'b0; #HALF;
        hold_n = 1'b0; #HALF;
        b = oe_n;
        for (int t = 0; t < 3; t++) begin
            si = ~si; sck = 1'b1; #HALF; sck = 1'b0; #HALF;
        end
        chk("R4 output undriven in pause", oe_n - b, 0);
        hold_n = 1'b1; #HALF;
    endtask

    task automatic xfer(input logic [7:0] tx, input int pause_at, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = tx[i]; #HALF;
            rx[i] = so;
            sck = 1'b1; #HALF;
            if (i == pause_at) pause_here();
        end
    endtask

    // ---- scenarios ----
    task automatic t_reset_state();
        chk("R3 reset so_oe", so_oe, 0);
        chk("R1 reset strobes", {wen_set, wen_clr, sr_wr_valid, wr_valid, mem_rd_en}, 0);
    endtask

    task automatic t_wren_wrdi();
        logic [7:0] d;
        int w = wen_n, c = clr_n;
        sel(); xfer(8'h0E, -1, d); desel();
        chk("R1 set strobe with bit3=1", wen_n - w, 1);
        sel(); xfer(8'h04, -1, d); desel();
        chk("R1 clear strobe", clr_n - c, 1);
    endtask

    task automatic t_read(input logic [15:0] a, input int p_addr, input int p_data, input string tag);
        logic [7:0] d0, d1, x;
        int r = rd_n;
        logic [AW-1:0] ea;
        ea = a[AW-1:0];
        sel();
        xfer(8'h03, -1, x); xfer(a[15:8], -1, x); xfer(a[7:0], p_addr, x);
        xfer(8'h00, p_data, d0); xfer(8'h00, -1, d1);
        desel();
        chk({tag, " first byte"}, d0, fmem(ea));
        chk({tag, " second byte"}, d1, fmem(ea + 1'b1));
        chk({tag, " request address"}, rd_a_log[r % 64], ea);
        chk({tag, " request count"}, rd_n - r, 3);
    endtask

    task automatic t_rdsr();
        logic [7:0] d0, d1, x;
        status_in = 8'h8E;
        sel(); xfer(8'h05, -1, x); xfer(8'h00, -1, d0);
        status_in = 8'h03;
        xfer(8'h00, -1, d1); desel();
        chk("R7 status byte 1", d0, 8'h8E);
        chk("R7 status resampled", d1, 8'h03);
    endtask

    task automatic t_wrsr();
        logic [7:0] x;
        int s = sr_n, w = wr_n;
        sel(); xfer(8'h01, -1, x); xfer(8'h8C, -1, x); xfer(8'h55, -1, x); desel();
        chk("R8 one status strobe", sr_n - s, 1);
        chk("R8 status byte", sr_last, 8'h8C);
        chk("R8 no array write", wr_n - w, 0);
    endtask

    task automatic t_write_page();
        logic [7:0] x;
        int w = wr_n;
        sel(); xfer(8'h02, -1, x); xfer(8'hF0, -1, x); xfer(8'h3E, -1, x);
        xfer(8'h11, -1, x); xfer(8'h22, -1, x); xfer(8'h33, -1, x); desel();
        chk("R9 byte count", wr_n - w, 3);
        chk("R9 addr 0", wr_a_log[w % 64], 12'h03E);
        chk("R9 addr 1", wr_a_log[(w+1) % 64], 12'h03F);
        chk("R9 page wrap", wr_a_log[(w+2) % 64], 12'h020);
        chk("R9 data last", wr_d_log[(w+2) % 64], 8'h33);
    endtask

    task automatic t_invalid();
        logic [7:0] x;
        int r = rd_n, o = oe_n, w = wen_n;
        sel(); xfer(8'h07, -1, x); xfer(8'h03, -1, x); xfer(8'h00, -1, x);
        xfer(8'h10, -1, x); xfer(8'h00, -1, x); desel();
        chk("R2 no read after bad op", rd_n - r, 0);
        chk("R2 output undriven", oe_n - o, 0);
        sel(); xfer(8'h86, -1, x); xfer(8'h06, -1, x); desel();
        chk("R2 upper nibble locks", wen_n - w, 0);
        sel(); xfer(8'h06, -1, x); desel();
        chk("R2 recovery after new select", wen_n - w, 1);
    endtask

    task automatic t_cs_high();
        int r = rd_n, o = oe_n, w = wen_n;
        logic [7:0] x;
        logic [7:0] pat;
        pat = 8'h03;
        for (int i = 0; i < 16; i++) begin
            si = pat[7 - (i % 8)]; sck = 1'b0; #HALF; sck = 1'b1; #HALF;
        end
        sck = 1'b0; #HALF;
        chk("R3 no request while deselected", rd_n - r, 0);
        chk("R3 undriven while deselected", oe_n - o, 0);
        sel(); xfer(8'h06, -1, x); desel();
        chk("R3 fresh command after select", wen_n - w, 1);
    endtask

    task automatic t_busy();
        logic [7:0] x, d;
        int w = wen_n, r = rd_n, o, wr = wr_n;
        busy = 1'b1;
        sel(); xfer(8'h06, -1, x); desel();
        chk("R10 set dropped", wen_n - w, 0);
        o = oe_n;
        sel(); xfer(8'h03, -1, x); xfer(8'h00, -1, x); xfer(8'h10, -1, x); xfer(8'h00, -1, x); desel();
        chk("R10 read dropped", rd_n - r, 0);
        chk("R10 no drive", oe_n - o, 0);
        sel(); xfer(8'h02, -1, x); xfer(8'h00, -1, x); xfer(8'h10, -1, x); xfer(8'hAA, -1, x); desel();
        chk("R10 write dropped", wr_n - wr, 0);
        status_in = 8'hFF;
        sel(); xfer(8'h05, -1, x); xfer(8'h00, -1, d); desel();
        chk("R10 status read honoured", d, 8'hFF);
        busy = 1'b0;
    endtask

    task automatic run_all();
        t_reset_state();
        t_wren_wrdi();
        t_read(16'hF123, -1, -1, "R5 read");
        t_read(16'h0FFF, -1, -1, "R6 wrap");
        t_rdsr();
        t_wrsr();
        t_write_page();
        t_invalid();
        t_cs_high();
        t_read(16'h0456, 3, 4, "R4 paused read");
        t_busy();
        mode3 = 1'b1;
        t_read(16'h0A5C, -1, -1, "R12 mode3 read");
        t_wren_wrdi();
        mode3 = 1'b0;
        sck = 1'b0; #HALF;
        chk("R11 output stable while clock high", viol_n, 0);
    endtask

    initial begin
        bit wd;
        wd = 1'b0;
        @(negedge clk);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        fork
            run_all();
            begin #(200000 * 5ns); wd = 1'b1; end
        join_any
        disable fork;
        if (wd) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule